// File: doc/BRIEF.md
# Program Fetch Address Router

This block sits between the instruction fetch unit and the two program memories of a small controller core. For every fetch it decides whether the word comes from on-chip program memory or from the external program bus. It can also decide that the fetch has no legal target, and then it marks the returned word as undefined. The decision depends on a two-bit processor-mode setting, which comes from configuration fuses. The block samples that setting once after reset and holds it until the next reset.

There are four modes. Microprocessor mode sends every fetch to the external bus. It is the mode that erased fuses select. Microcontroller mode fetches only from on-chip memory. Protected microcontroller mode does the same and also raises a code-protect indication. Extended microcontroller mode splits the address space per fetch: low addresses go on chip and everything above the on-chip size goes off chip.

The top 512 words of the address space, from FE00h to FFFFh, hold configuration words, test memory and boot memory. Those words can be reached only in the two modes that allow external fetching. In those two modes the words are served by the on-chip side. The decision is registered, so the strobes appear one clock after the fetch request.

Top module: `pmem_route`

## Requirements
- R1: The mode encoding is 2'b11 = microprocessor (the erased state), 2'b10 = extended microcontroller, 2'b01 = microcontroller and 2'b00 = protected microcontroller. While reset is held, and on any cycle after reset without a registered fetch, `int_sel`, `ext_sel`, `undef_data` and `ext_addr` are all zero.
- R2: The internal reset is released two clocks after `rst_n` rises, and `mode_cfg` is captured on the first clock after that release. Later changes on `mode_cfg` have no effect until the next reset.
- R3: A fetch presented with `fetch_vld` high at a rising clock edge produces its result on the outputs right after that edge, and the result holds until the next edge.
- R4: In microprocessor mode, a fetch to any address below FE00h asserts `ext_sel`.
- R5: In microcontroller mode, a fetch below `INT_WORDS` asserts `int_sel`. A fetch at or above `INT_WORDS` and below FE00h asserts `undef_data`.
- R6: Protected microcontroller mode routes fetches exactly as microcontroller mode does, and `code_prot` is high in that mode. In every other mode `code_prot` is low.
- R7: In extended microcontroller mode, a fetch below `INT_WORDS` asserts `int_sel`. A fetch at or above `INT_WORDS` and below FE00h asserts `ext_sel`.
- R8: A fetch to the reserved area FE00h..FFFF asserts `undef_data` in the two internal-only modes, and asserts `int_sel` in the other two modes.
- R9: `ext_addr` equals the fetched address when `ext_sel` is high, and is zero otherwise.
- R10: Each registered fetch asserts exactly one of `int_sel`, `ext_sel` and `undef_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_cfg | input | 2 | Processor-mode setting from the configuration fuses |
| fetch_vld | input | 1 | A fetch is requested this cycle |
| fetch_addr | input | 16 | Program word address |
| int_sel | output | 1 | Fetch is served by on-chip memory |
| ext_sel | output | 1 | Fetch is driven onto the external bus |
| ext_addr | output | 16 | Address for the external bus |
| undef_data | output | 1 | The returned word is undefined |
| code_prot | output | 1 | Code protection is active |

## Verification
The assertions assume that `mode_cfg` is a steady fuse value while the internal reset is being released. They also assume that `fetch_vld` and `fetch_addr` are settled at each rising edge. The stimulus therefore holds `mode_cfg` constant from reset assertion until four clocks after release, and only then changes it. Fetch inputs are driven on falling edges only. Every mode is entered through its own reset. The reserved-area and on-chip-size boundaries are walked in each mode, together with pseudo-random addresses.

// File: rtl/pmem_route_pkg.sv
package pmem_route_pkg;
  typedef enum logic [1:0] {
    MODE_PROT = 2'b00,
    MODE_MCU  = 2'b01,
    MODE_EXT  = 2'b10,
    MODE_MPU  = 2'b11
  } pmode_e;

  typedef enum logic [1:0] {
    TGT_NONE  = 2'b00,
    TGT_INT   = 2'b01,
    TGT_EXT   = 2'b10,
    TGT_UNDEF = 2'b11
  } ptgt_e;
endpackage

// File: rtl/pmem_rst_sync.sv
module pmem_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_int_n = sync_q[STAGES-1];
endmodule

// File: rtl/pmem_mode_latch.sv
module pmem_mode_latch
  import pmem_route_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_cfg,
  output pmode_e     mode,
  output logic       mode_ok
);
  pmode_e mode_q, mode_d;
  logic   took_q, took_d;
  logic   cap_en;

  assign cap_en = !took_q;

  always_comb begin
    mode_d = mode_q;
    took_d = took_q;
    if (cap_en) begin
      mode_d = pmode_e'(mode_cfg);
      took_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_MPU;
      took_q <= 1'b0;
    end else if (cap_en) begin
      mode_q <= mode_d;
      took_q <= took_d;
    end
  end

  // Before the capture edge the live fuse value is used
  assign mode    = took_q ? mode_q : pmode_e'(mode_cfg);
  assign mode_ok = took_q;
endmodule

// File: rtl/pmem_addr_decode.sv
module pmem_addr_decode
  import pmem_route_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int INT_WORDS = 8192,
  parameter int RSV_BASE  = 'hFE00
) (
  input  pmode_e            mode,
  input  logic              vld,
  input  logic [ADDR_W-1:0] addr,
  output ptgt_e             tgt
);
  localparam logic [ADDR_W:0] INT_LIM = (ADDR_W+1)'(INT_WORDS);
  localparam logic [ADDR_W:0] RSV_LIM = (ADDR_W+1)'(RSV_BASE);

  logic in_int, in_rsv, int_only;

  always_comb begin
    in_int   = {1'b0, addr} < INT_LIM;
    in_rsv   = {1'b0, addr} >= RSV_LIM;
    int_only = (mode == MODE_MCU) || (mode == MODE_PROT);
    tgt      = TGT_NONE;
    if (vld) begin
      if (in_rsv)        tgt = int_only ? TGT_UNDEF : TGT_INT;
      else if (int_only) tgt = in_int ? TGT_INT : TGT_UNDEF;
      else if (mode == MODE_EXT) tgt = in_int ? TGT_INT : TGT_EXT;
      else               tgt = TGT_EXT;
    end
  end
endmodule

// File: rtl/pmem_route.sv
module pmem_route
  import pmem_route_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int INT_WORDS = 8192,
  parameter int RSV_BASE  = 'hFE00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_cfg,
  input  logic              fetch_vld,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              int_sel,
  output logic              ext_sel,
  output logic [ADDR_W-1:0] ext_addr,
  output logic              undef_data,
  output logic              code_prot
);
  logic   rst_int_n;
  pmode_e mode;
  logic   mode_ok;
  ptgt_e  tgt;

  logic              int_d, ext_d, und_d, cp_d;
  logic [ADDR_W-1:0] xa_d;
  logic              int_q, ext_q, und_q, cp_q;
  logic [ADDR_W-1:0] xa_q;
  logic              out_en;

  pmem_rst_sync #(.STAGES(2)) u_rsync (
    .clk(clk), .rst_n(rst_n), .rst_int_n(rst_int_n)
  );

  pmem_mode_latch u_mode (
    .clk(clk), .rst_n(rst_int_n), .mode_cfg(mode_cfg),
    .mode(mode), .mode_ok(mode_ok)
  );

  pmem_addr_decode #(
    .ADDR_W(ADDR_W), .INT_WORDS(INT_WORDS), .RSV_BASE(RSV_BASE)
  ) u_dec (
    .mode(mode), .vld(fetch_vld), .addr(fetch_addr), .tgt(tgt)
  );

  // Update when a fetch arrives or when a previous result must clear
  assign out_en = fetch_vld | int_q | ext_q | und_q | !mode_ok;

  always_comb begin
    int_d = (tgt == TGT_INT);
    ext_d = (tgt == TGT_EXT);
    und_d = (tgt == TGT_UNDEF);
    xa_d  = (tgt == TGT_EXT) ? fetch_addr : '0;
    cp_d  = (mode == MODE_PROT);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      int_q <= 1'b0;
      ext_q <= 1'b0;
      und_q <= 1'b0;
      xa_q  <= '0;
      cp_q  <= 1'b0;
    end else if (out_en) begin
      int_q <= int_d;
      ext_q <= ext_d;
      und_q <= und_d;
      xa_q  <= xa_d;
      cp_q  <= cp_d;
    end
  end

  assign int_sel    = int_q;
  assign ext_sel    = ext_q;
  assign undef_data = und_q;
  assign ext_addr   = xa_q;
  assign code_prot  = cp_q;
endmodule

// File: rtl/pmem_route_chk.sv
module pmem_route_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fetch_vld,
  input logic              int_sel,
  input logic              ext_sel,
  input logic [ADDR_W-1:0] ext_addr,
  input logic              undef_data,
  input logic              code_prot
);
  logic [2:0] age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            age_q <= '0;
    else if (age_q != 3'd7) age_q <= age_q + 3'd1;
  end

  a_r10_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({int_sel, ext_sel, undef_data}));

  a_r9_addr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_sel |-> (ext_addr == '0));

  a_r6_prot_no_ext: assert property (@(posedge clk) disable iff (!rst_n)
    code_prot |-> !ext_sel);

  a_r2_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 3'd5) |-> $stable(code_prot));

  a_r3_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 3'd4 && !fetch_vld) |=> !(int_sel || ext_sel || undef_data));

  a_r10_fetch_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 3'd4 && fetch_vld) |=> (int_sel || ext_sel || undef_data));
endmodule

bind pmem_route pmem_route_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_vld(fetch_vld),
  .int_sel(int_sel), .ext_sel(ext_sel), .ext_addr(ext_addr),
  .undef_data(undef_data), .code_prot(code_prot)
);

// File: tb/tb_pmem_route.sv
module tb_pmem_route;
  localparam int CLK_PER = 10;
  localparam int INT_W   = 8192;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  mode_cfg;
  logic        fetch_vld;
  logic [15:0] fetch_addr;
  logic        int_sel, ext_sel, undef_data, code_prot;
  logic [15:0] ext_addr;

  int n_chk = 0, n_bad = 0;
  int m_mode;
  logic [15:0] seed = 16'hACE1;

  always #(CLK_PER/2) clk = ~clk;

  pmem_route #(.INT_WORDS(INT_W)) dut (
    .clk(clk), .rst_n(rst_n), .mode_cfg(mode_cfg), .fetch_vld(fetch_vld),
    .fetch_addr(fetch_addr), .int_sel(int_sel), .ext_sel(ext_sel),
    .ext_addr(ext_addr), .undef_data(undef_data), .code_prot(code_prot)
  );

  task automatic chk(string tag, logic [19:0] act, logic [19:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [19:0] pack_out();
    return {int_sel, ext_sel, undef_data, code_prot, ext_addr};
  endfunction

  // expected {int,ext,undef,cp,addr}
  function automatic logic [19:0] model(int md, bit v, logic [15:0] a);
    bit i = 0, e = 0, u = 0;
    bit only_int = (md == 1) || (md == 0);
    if (v) begin
      if (a >= 16'hFE00)   begin if (only_int) u = 1; else i = 1; end
      else if (only_int)   begin if (a < INT_W) i = 1; else u = 1; end
      else if (md == 2)    begin if (a < INT_W) i = 1; else e = 1; end
      else e = 1;
    end
    return {i, e, u, (md == 0), e ? a : 16'h0};
  endfunction

  function automatic string tag_for(int md, logic [15:0] a);
    if (a >= 16'hFE00) return "R8";
    case (md)
      3: return "R4";
      2: return "R7";
      1: return "R5";
      default: return "R6";
    endcase
  endfunction

  // Present one fetch at a falling edge and check after the next rising edge
  task automatic fetch(bit v, logic [15:0] a);
    logic [19:0] exp;
    fetch_vld = v; fetch_addr = a;
    exp = model(m_mode, v, a);
    @(negedge clk);
    chk(v ? tag_for(m_mode, a) : "R3", pack_out(), exp);
    if (ext_sel) chk("R9", {4'h0, ext_addr}, {4'h0, a});
    if (v) chk("R10", 20'(int'(int_sel) + int'(ext_sel) + int'(undef_data)), 20'd1);
  endtask

  task automatic do_reset(int md);
    @(negedge clk);
    rst_n = 1'b0; fetch_vld = 1'b0; fetch_addr = '0; mode_cfg = 2'(md);
    @(negedge clk);
    chk("R1", pack_out(), 20'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    m_mode = md;
    chk("R1", pack_out(), {3'b000, (md == 0), 16'h0});
    mode_cfg = ~2'(md);   // later fuse changes must be ignored
  endtask

  initial begin : watchdog
    #(CLK_PER * 150000);
    n_bad++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode_cfg = 2'b11; fetch_vld = 1'b0; fetch_addr = '0;
    for (int md = 3; md >= 0; md--) begin
      do_reset(md);
      fetch(1'b1, 16'h0000);
      fetch(1'b1, 16'(INT_W - 1));
      fetch(1'b1, 16'(INT_W));
      fetch(1'b0, 16'h1234);
      fetch(1'b1, 16'hFDFF);
      fetch(1'b1, 16'hFE00);
      fetch(1'b1, 16'hFE0F);
      fetch(1'b1, 16'hFE10);
      fetch(1'b1, 16'hFF5F);
      fetch(1'b1, 16'hFF60);
      fetch(1'b1, 16'hFFFF);
      fetch(1'b0, 16'hFFFF);
      chk("R2", {19'h0, code_prot}, {19'h0, (md == 0)});
      for (int k = 0; k < 40; k++) begin
        seed = {seed[14:0], seed[15] ^ seed[13] ^ seed[12] ^ seed[10]};
        fetch(seed[0] | seed[3], seed);
      end
      // on-chip size boundary reached through the extended split
      fetch(1'b1, 16'(INT_W + 1));
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule